// File: doc/BRIEF.md
# Program Counter Integrity Checker

This block sits next to an instruction fetch stage and watches the stream of fetch addresses it produces. Each fetch that the stage accepts is compared with the address the previous accepted fetch implies. That implied address is the previous address plus 2 bytes for a compressed instruction, or plus 4 bytes for a full-width one. A fault injected into the program counter breaks this arithmetic chain. The block then raises a major alert that stays high until reset.

Control-flow changes break the chain on purpose, so the comparison is masked in two cases. One is the first accepted fetch after reset. The other is any fetch that follows a redirect strobe from a taken branch, a jump or an exception entry. The block keeps its own registered copy of the expected address and an "armed" flag. Both change only on accepted fetches or redirects. Stall cycles leave them untouched.

Top module: `pc_integrity_chk`

## Requirements
- R1: After reset the alert output is low, and the first accepted fetch after reset is never compared, whatever its address.
- R2: When an accepted fetch follows an accepted full-width fetch (compressed flag 0), its address must equal the previous address plus 4. If it does, the alert stays low.
- R3: When an accepted fetch follows an accepted compressed fetch (compressed flag 1), its address must equal the previous address plus 2. An address of previous plus 4 in that case is a mismatch.
- R4: A compared fetch whose address differs from the expected address drives the alert high on the clock edge that accepts that fetch, so the alert is visible in the following cycle.
- R5: Once high, the alert stays high through later fetches, stalls and redirects, until reset.
- R6: A redirect strobe in a cycle without a fetch disarms the check. The next accepted fetch is not compared, and its address becomes the base for the fetch after it.
- R7: A redirect strobe in the same cycle as an accepted fetch exempts that fetch from comparison. The expected address is still reloaded from that fetch's own address and size.
- R8: In cycles with the fetch-valid strobe low and no redirect, the address and compressed inputs are ignored, and the expected address and armed state hold.
- R9: The expected address is computed modulo 2^PC_W, so a sequential fetch across the top of the address space wraps to zero without an alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_vld_i | input | 1 | High when the fetch stage accepts an instruction this cycle |
| fetch_pc_i | input | PC_W | Address of the accepted instruction |
| fetch_rvc_i | input | 1 | 1 when the accepted instruction is compressed (2 bytes), 0 when it is 4 bytes |
| redirect_i | input | 1 | Control-flow change strobe: branch, jump or exception entry |
| alert_major_o | output | 1 | Sticky major alert for a program counter mismatch |

## Verification
A redirect and an accepted fetch can land in the same cycle. In that cycle, suppression of the comparison and reloading of the expected address must both take effect. The bench provokes this by driving a redirect together with a fetch at a wrong, arbitrary address. It expects no alert, then follows with fetches that are sequential to that new address and again expects no alert. A scoreboard model built from the requirements predicts the alert level for every cycle. A mismatch also arrives while the alert is already set, to confirm the sticky level does not toggle.

// File: rtl/pcchk_pkg.sv
package pcchk_pkg;

    // byte sizes of the two instruction formats
    localparam int unsigned STEP_WIDE   = 4;
    localparam int unsigned STEP_NARROW = 2;

    // outcome of one cycle's comparison
    typedef enum logic [1:0] {
        CHK_SKIP = 2'd0,
        CHK_PASS = 2'd1,
        CHK_FAIL = 2'd2
    } chk_res_e;

endpackage

// File: rtl/pcchk_step.sv
// Sequential successor of a fetch address.
module pcchk_step #(
    parameter int unsigned PC_W = 32
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic            rvc_i,
    output logic [PC_W-1:0] next_o
);
    import pcchk_pkg::*;

    localparam logic [PC_W-1:0] INC_WIDE   = PC_W'(STEP_WIDE);
    localparam logic [PC_W-1:0] INC_NARROW = PC_W'(STEP_NARROW);

    logic [PC_W-1:0] inc;

    always_comb begin
        inc    = rvc_i ? INC_NARROW : INC_WIDE;
        next_o = pc_i + inc;   // wraps modulo 2^PC_W
    end
endmodule

// File: rtl/pcchk_cmp.sv
// Decides whether this cycle's fetch is compared, and the result.
module pcchk_cmp #(
    parameter int unsigned PC_W = 32
) (
    input  logic                fetch_vld_i,
    input  logic                redirect_i,
    input  logic                armed_i,
    input  logic [PC_W-1:0]     pc_i,
    input  logic [PC_W-1:0]     exp_i,
    output pcchk_pkg::chk_res_e res_o
);
    import pcchk_pkg::*;

    always_comb begin
        if (!fetch_vld_i || !armed_i || redirect_i) begin
            res_o = CHK_SKIP;
        end else if (pc_i == exp_i) begin
            res_o = CHK_PASS;
        end else begin
            res_o = CHK_FAIL;
        end
    end
endmodule

// File: rtl/pc_integrity_chk.sv
module pc_integrity_chk #(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            fetch_vld_i,
    input  logic [PC_W-1:0] fetch_pc_i,
    input  logic            fetch_rvc_i,
    input  logic            redirect_i,
    output logic            alert_major_o
);
    import pcchk_pkg::*;

    typedef struct packed {
        logic [PC_W-1:0] exp_pc;
        logic            armed;
        logic            alert;
    } state_t;

    state_t          st_d, st_q;
    logic [PC_W-1:0] succ_pc;
    chk_res_e        res;
    logic [PC_W-1:0] exp_pc_q;
    logic            armed_q;

    assign exp_pc_q = st_q.exp_pc;
    assign armed_q  = st_q.armed;

    pcchk_step #(.PC_W(PC_W)) u_step (
        .pc_i   (fetch_pc_i),
        .rvc_i  (fetch_rvc_i),
        .next_o (succ_pc)
    );

    pcchk_cmp #(.PC_W(PC_W)) u_cmp (
        .fetch_vld_i (fetch_vld_i),
        .redirect_i  (redirect_i),
        .armed_i     (st_q.armed),
        .pc_i        (fetch_pc_i),
        .exp_i       (st_q.exp_pc),
        .res_o       (res)
    );

    always_comb begin
        st_d = st_q;
        if (fetch_vld_i) begin
            // every accepted fetch becomes the base for the next one
            st_d.exp_pc = succ_pc;
            st_d.armed  = 1'b1;
        end else if (redirect_i) begin
            st_d.armed  = 1'b0;
        end
        if (res == CHK_FAIL) begin
            st_d.alert = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alert_major_o = st_q.alert;
endmodule

// File: rtl/pcchk_sva.sv
module pcchk_sva #(
    parameter int unsigned PC_W = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            fetch_vld_i,
    input logic [PC_W-1:0] fetch_pc_i,
    input logic            fetch_rvc_i,
    input logic            redirect_i,
    input logic            alert_major_o,
    input logic [PC_W-1:0] exp_pc_q,
    input logic            armed_q
);
    localparam logic [PC_W-1:0] TWO  = PC_W'(2);
    localparam logic [PC_W-1:0] FOUR = PC_W'(4);

    // R4
    mismatch_alert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fetch_vld_i && armed_q && !redirect_i && fetch_pc_i != exp_pc_q) |=> alert_major_o);

    // R5
    alert_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alert_major_o |=> alert_major_o);

    // R1
    alert_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!alert_major_o && (!fetch_vld_i || !armed_q || redirect_i)) |=> !alert_major_o);

    // R6
    redirect_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (redirect_i && !fetch_vld_i) |=> !armed_q);

    // R7
    fetch_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_vld_i |=> (armed_q &&
            exp_pc_q == $past(fetch_pc_i) + ($past(fetch_rvc_i) ? TWO : FOUR)));

    // R8
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fetch_vld_i && !redirect_i) |=> ($stable(exp_pc_q) && $stable(armed_q)));
endmodule

bind pc_integrity_chk pcchk_sva #(.PC_W(PC_W)) u_sva (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_vld_i   (fetch_vld_i),
    .fetch_pc_i    (fetch_pc_i),
    .fetch_rvc_i   (fetch_rvc_i),
    .redirect_i    (redirect_i),
    .alert_major_o (alert_major_o),
    .exp_pc_q      (exp_pc_q),
    .armed_q       (armed_q)
);

// File: tb/pc_integrity_chk_tb.sv
`timescale 1ns/1ps
module pc_integrity_chk_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fv = 1'b0;
    logic [31:0] pc = '0;
    logic        rvc = 1'b0;
    logic        rd = 1'b0;
    logic        alert;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        bit    exp;
        string tag;
    } item_t;
    item_t sb[$];

    // reference model state
    logic [31:0] m_exp = '0;
    bit          m_armed = 1'b0;
    bit          m_alert = 1'b0;

    always #2.5 clk = ~clk;

    pc_integrity_chk #(.PC_W(32)) u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .fetch_vld_i   (fv),
        .fetch_pc_i    (pc),
        .fetch_rvc_i   (rvc),
        .redirect_i    (rd),
        .alert_major_o (alert)
    );

    task automatic check(input bit act, input bit exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: alert actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected alert pushed for the next edge
    task automatic drive(input bit v, input logic [31:0] a, input bit c,
                         input bit r, input string tag);
        @(posedge clk);
        #1;
        fv = v; pc = a; rvc = c; rd = r;
        if (v && m_armed && !r && a != m_exp) m_alert = 1'b1;
        if (v) begin
            m_exp   = a + (c ? 32'd2 : 32'd4);
            m_armed = 1'b1;
        end else if (r) begin
            m_armed = 1'b0;
        end
        sb.push_back('{due: cyc + 1, exp: m_alert, tag: tag});
    endtask

    task automatic do_reset();
        wait (sb.size() == 0);
        @(posedge clk);
        #1;
        rst_n = 1'b0; fv = 1'b0; rd = 1'b0;
        m_armed = 1'b0; m_alert = 1'b0; m_exp = '0;
        repeat (2) @(posedge clk);
        #1;
        check(alert, 1'b0, "R1 reset value");
        rst_n = 1'b1;
    endtask

    // monitor: pops and compares away from the edge
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            while (sb.size() > 0 && sb[0].due == cyc) begin
                item_t it;
                it = sb.pop_front();
                check(alert, it.exp, it.tag);
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        drive(1, 32'h0000_1234, 0, 0, "R1 first fetch unchecked");
        drive(1, 32'h0000_1238, 0, 0, "R2 seq +4");
        drive(1, 32'h0000_123C, 1, 0, "R2 seq +4 then compressed");
        drive(1, 32'h0000_123E, 1, 0, "R3 seq +2");
        drive(1, 32'h0000_1240, 0, 0, "R3 seq +2 again");
        drive(0, 32'hDEAD_BEEF, 1, 0, "R8 stall garbage pc");
        drive(0, 32'h0BAD_0BAD, 0, 0, "R8 stall garbage pc");
        drive(1, 32'h0000_1244, 0, 0, "R8 resume after stall");
        drive(0, 32'h0, 0, 1, "R6 redirect alone");
        drive(0, 32'h5555_0000, 0, 0, "R6 stall after redirect");
        drive(1, 32'h8000_0100, 0, 0, "R6 target unchecked");
        drive(1, 32'h8000_0104, 1, 0, "R6 seq from target");
        drive(1, 32'h4000_0000, 0, 1, "R7 redirect with fetch");
        drive(1, 32'h4000_0004, 0, 0, "R7 seq from reloaded base");
        drive(1, 32'h7000_0002, 1, 1, "R7 redirect with compressed fetch");
        drive(1, 32'h7000_0004, 0, 0, "R7 reload honours size");
        drive(0, 32'h0, 0, 1, "R9 redirect");
        drive(1, 32'hFFFF_FFFC, 0, 0, "R9 fetch at top");
        drive(1, 32'h0000_0000, 1, 0, "R9 wrap to zero");
        drive(1, 32'h0000_0002, 0, 0, "R9 after wrap");
        drive(1, 32'h0000_0016, 0, 0, "R4 single bit flip");
        drive(1, 32'h0000_001A, 0, 0, "R5 sticky on good fetch");
        drive(0, 32'h0, 0, 1, "R5 sticky across redirect");
        drive(1, 32'h9000_0000, 0, 0, "R5 sticky after redirect");
        drive(1, 32'h9000_0010, 0, 0, "R5 second mismatch");
        drive(0, 32'h0, 0, 0, "R5 idle");
        do_reset();
        drive(1, 32'h2000_0000, 1, 0, "R1 first fetch after reset");
        drive(1, 32'h2000_0004, 0, 0, "R3 +4 after compressed flagged");
        drive(0, 32'h0, 0, 0, "R5 hold");
        do_reset();
        drive(1, 32'h3000_0000, 0, 0, "R1 base");
        drive(1, 32'h3000_0002, 0, 0, "R2 +2 after wide flagged");
        drive(0, 32'h0, 0, 0, "R5 hold");
        wait (sb.size() == 0);
        @(posedge clk);
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule